// File: doc/BRIEF.md
# Fetch Serialization Barrier Tracker

This block sits in an instruction fetch path and looks at one fetched instruction per cycle. It reads the instruction's ordering flags and decides one of three things. The instruction can pass straight through. It can pass through and arm a one-shot request that forces the following instruction to wait for an empty machine. Or it must itself wait for an empty machine before it may be delivered.

An instruction that must wait is parked in a single holding slot, and the block raises a stall request towards fetch. It stays stalled until two conditions hold in the same cycle: the back-end reorder buffer reports empty and the fetch queue reports empty. It then re-issues the parked instruction as the next delivered instruction, with its wait-before mark removed, and resumes normal flow. A squash from the back end can discard a parked instruction that is younger than the squash point.

Three counters are kept: serializing barriers handled, temporary barriers seen, and cycles spent stalled.

Top module: `ser_barrier_tracker`

## Requirements
- R1: After synchronous reset, `out_valid`, `stall_req`, `ser_next`, `held_valid` and all three counters are zero.
- R2: Flag encoding for `in_flags` and `out_flags` is bit 5 wait-before, bit 4 wait-after, bit 3 special-register access, bit 2 store-conditional, bit 1 temporary, bit 0 handled. An instruction accepted while not stalled that does not park appears on the output one cycle later with its sequence number, tag and flags (apart from R3/R4 changes), and leaves the counters unchanged when none of bits 5..2 applies.
- R3: An accepted store-conditional or wait-after instruction without the handled bit, and not parked, is forwarded with bit 0 set; it increments the serializing counter and sets `ser_next`.
- R4: When `ser_next` is set, the next accepted instruction has bit 5 forced on, and `ser_next` clears.
- R5: An accepted instruction with special-register access or (effective) wait-before, and without the handled bit, is parked. It is not forwarded, and from the next cycle `stall_req` and `held_valid` are high.
- R6: A parked instruction without the temporary bit gets the handled bit and increments the serializing counter. A parked temporary instruction increments the temporary counter instead and keeps handled clear.
- R7: While `stall_req` is high, `in_valid` instructions are ignored: nothing is forwarded, `ser_next` and the serializing and temporary counters do not change.
- R8: The stall counter increments by one for every cycle in which `stall_req` is high.
- R9: The parked instruction is released only after a cycle where `rob_empty` and `fq_empty` are both high. One cycle later `stall_req` is still high. On the following edge the parked instruction is delivered with bit 5 cleared, and `stall_req` drops.
- R10: A squash while stalled discards the parked instruction only if its sequence number is greater than `squash_seq`. The block then returns to running with no delivery. Otherwise the squash has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched instruction present |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_tag | input | TAG_W | Opaque instruction payload (address/identifier) |
| in_flags | input | 6 | Ordering flags, encoding per R2 |
| rob_empty | input | 1 | Back-end reorder buffer empty |
| fq_empty | input | 1 | Fetch queue holds no instructions |
| squash_valid | input | 1 | Squash from back end this cycle |
| squash_seq | input | SEQ_W | Squash point; younger instructions are discarded |
| out_valid | output | 1 | Delivered instruction valid |
| out_seq | output | SEQ_W | Delivered sequence number |
| out_tag | output | TAG_W | Delivered payload |
| out_flags | output | 6 | Delivered flags |
| stall_req | output | 1 | Fetch must hold; input ignored |
| ser_next | output | 1 | One-shot wait-before request for next instruction |
| held_valid | output | 1 | Holding slot occupied |
| cnt_serial | output | CNT_W | Serializing barriers handled |
| cnt_temp | output | CNT_W | Temporary barriers seen |
| cnt_stall | output | CNT_W | Cycles with stall_req high |

## Verification
The assertions watch, on every cycle, the local cause-and-effect rules: forwarding of plain instructions, arming and consuming of `ser_next`, parking, the freeze of the serializing counters while stalled, the stall counter step, staying blocked until both empty signals agree, the release delivery without wait-before, and squash discard. Only the bench scenarios can show whole sequences end to end. These cover a wait-after instruction followed by an instruction that is forced to park and later replayed. They also cover a temporary barrier that comes back still unhandled, the exact stall-cycle totals across a long wait, and a squash at an older point that leaves the barrier in place.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    localparam int FLAG_W     = 6;
    localparam int NUM_CNT    = 3;
    localparam int CNT_SERIAL = 0;
    localparam int CNT_TEMP   = 1;
    localparam int CNT_STALL  = 2;

    // Bit order is part of the port encoding (bit 5 down to bit 0).
    typedef struct packed {
        logic ser_before;
        logic ser_after;
        logic spr;
        logic store_cond;
        logic temp;
        logic handled;
    } sbt_flags_t;

    typedef enum logic [1:0] {
        SBT_RUN     = 2'd0,
        SBT_BLOCKED = 2'd1,
        SBT_RELEASE = 2'd2
    } sbt_state_e;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_PARK = 2'd1,
        ACT_ARM  = 2'd2
    } sbt_act_e;

    function automatic sbt_flags_t sbt_release_flags(sbt_flags_t f);
        sbt_flags_t r;
        r = f;
        r.ser_before = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sbt_classify.sv
module sbt_classify
    import sbt_pkg::*;
(
    input  sbt_flags_t flags_i,
    input  logic       ser_next_i,
    output sbt_act_e   act_o,
    output sbt_flags_t flags_o,
    output logic       inc_serial_o,
    output logic       inc_temp_o
);

    always_comb begin
        flags_o            = flags_i;
        flags_o.ser_before = flags_i.ser_before | ser_next_i;
        act_o              = ACT_PASS;
        inc_serial_o       = 1'b0;
        inc_temp_o         = 1'b0;
        if ((flags_i.spr | flags_o.ser_before) & ~flags_i.handled) begin
            act_o = ACT_PARK;
            if (flags_i.temp) begin
                inc_temp_o = 1'b1;
            end else begin
                inc_serial_o    = 1'b1;
                flags_o.handled = 1'b1;
            end
        end else if ((flags_i.store_cond | flags_i.ser_after) & ~flags_i.handled) begin
            act_o           = ACT_ARM;
            flags_o.handled = 1'b1;
            inc_serial_o    = 1'b1;
        end
    end

endmodule

// File: rtl/sbt_hold.sv
module sbt_hold
    import sbt_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  sbt_act_e         act_i,
    input  sbt_flags_t       flags_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             rob_empty_i,
    input  logic             fq_empty_i,
    input  logic             squash_valid_i,
    input  logic [SEQ_W-1:0] squash_seq_i,
    output sbt_state_e       state_o,
    output logic             ser_next_o,
    output logic             held_valid_o,
    output logic             out_valid_o,
    output logic [SEQ_W-1:0] out_seq_o,
    output logic [TAG_W-1:0] out_tag_o,
    output sbt_flags_t       out_flags_o
);

    logic [SEQ_W-1:0] held_seq;
    logic [TAG_W-1:0] held_tag;
    sbt_flags_t       held_flags;
    logic             kill;
    logic             drained;

    assign kill    = (state_o != SBT_RUN) & held_valid_o & squash_valid_i
                   & (held_seq > squash_seq_i);
    assign drained = rob_empty_i & fq_empty_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o      <= SBT_RUN;
            ser_next_o   <= 1'b0;
            held_valid_o <= 1'b0;
            held_seq     <= '0;
            held_tag     <= '0;
            held_flags   <= '0;
            out_valid_o  <= 1'b0;
            out_seq_o    <= '0;
            out_tag_o    <= '0;
            out_flags_o  <= '0;
        end else begin
            out_valid_o <= 1'b0;
            case (state_o)
                SBT_RUN: begin
                    if (accept_i) begin
                        ser_next_o <= (act_i == ACT_ARM);
                        if (act_i == ACT_PARK) begin
                            held_valid_o <= 1'b1;
                            held_seq     <= seq_i;
                            held_tag     <= tag_i;
                            held_flags   <= flags_i;
                            state_o      <= SBT_BLOCKED;
                        end else begin
                            out_valid_o <= 1'b1;
                            out_seq_o   <= seq_i;
                            out_tag_o   <= tag_i;
                            out_flags_o <= flags_i;
                        end
                    end
                end
                SBT_BLOCKED: begin
                    if (kill) begin
                        held_valid_o <= 1'b0;
                        state_o      <= SBT_RUN;
                    end else if (drained) begin
                        state_o <= SBT_RELEASE;
                    end
                end
                SBT_RELEASE: begin
                    held_valid_o <= 1'b0;
                    state_o      <= SBT_RUN;
                    if (!kill) begin
                        out_valid_o <= 1'b1;
                        out_seq_o   <= held_seq;
                        out_tag_o   <= held_tag;
                        out_flags_o <= sbt_release_flags(held_flags);
                    end
                end
                default: state_o <= SBT_RUN;
            endcase
        end
    end

    // R9: no release without both empty indications
    assert_wait_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == SBT_BLOCKED && !drained && !kill) |=> state_o == SBT_BLOCKED);

    // R9: release delivers the parked instruction without its wait-before mark
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == SBT_RELEASE && !kill)
        |=> out_valid_o && !out_flags_o.ser_before && out_seq_o == $past(held_seq));

    // R10: younger parked barrier discarded on squash
    assert_squash_drop_R10: assert property (@(posedge clk) disable iff (rst)
        kill |=> state_o == SBT_RUN && !held_valid_o && !out_valid_o);

endmodule

// File: rtl/sbt_count.sv
module sbt_count #(
    parameter int N = 3,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        inc_i,
    output logic [N-1:0][W-1:0] cnt_o
);

    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_o[g] <= '0;
            end else if (inc_i[g]) begin
                cnt_o[g] <= cnt_o[g] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ser_barrier_tracker.sv
module ser_barrier_tracker
    import sbt_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int TAG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic              rob_empty,
    input  logic              fq_empty,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              out_valid,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [TAG_W-1:0]  out_tag,
    output logic [FLAG_W-1:0] out_flags,
    output logic              stall_req,
    output logic              ser_next,
    output logic              held_valid,
    output logic [CNT_W-1:0]  cnt_serial,
    output logic [CNT_W-1:0]  cnt_temp,
    output logic [CNT_W-1:0]  cnt_stall
);

    sbt_flags_t                      flags_in;
    sbt_flags_t                      flags_eff;
    sbt_flags_t                      flags_out;
    sbt_act_e                        act;
    sbt_state_e                      state;
    logic                            inc_serial;
    logic                            inc_temp;
    logic                            accept;
    logic [NUM_CNT-1:0]              cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all;

    assign flags_in  = sbt_flags_t'(in_flags);
    assign accept    = in_valid & (state == SBT_RUN);
    assign stall_req = (state != SBT_RUN);
    assign out_flags = flags_out;

    sbt_classify u_classify (
        .flags_i      (flags_in),
        .ser_next_i   (ser_next),
        .act_o        (act),
        .flags_o      (flags_eff),
        .inc_serial_o (inc_serial),
        .inc_temp_o   (inc_temp)
    );

    sbt_hold #(.SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_hold (
        .clk            (clk),
        .rst            (rst),
        .accept_i       (accept),
        .act_i          (act),
        .flags_i        (flags_eff),
        .seq_i          (in_seq),
        .tag_i          (in_tag),
        .rob_empty_i    (rob_empty),
        .fq_empty_i     (fq_empty),
        .squash_valid_i (squash_valid),
        .squash_seq_i   (squash_seq),
        .state_o        (state),
        .ser_next_o     (ser_next),
        .held_valid_o   (held_valid),
        .out_valid_o    (out_valid),
        .out_seq_o      (out_seq),
        .out_tag_o      (out_tag),
        .out_flags_o    (flags_out)
    );

    always_comb begin
        cnt_inc             = '0;
        cnt_inc[CNT_SERIAL] = accept & inc_serial;
        cnt_inc[CNT_TEMP]   = accept & inc_temp;
        cnt_inc[CNT_STALL]  = stall_req;
    end

    sbt_count #(.N(NUM_CNT), .W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .inc_i (cnt_inc),
        .cnt_o (cnt_all)
    );

    assign cnt_serial = cnt_all[CNT_SERIAL];
    assign cnt_temp   = cnt_all[CNT_TEMP];
    assign cnt_stall  = cnt_all[CNT_STALL];

    // R2: plain instruction forwarded unchanged one cycle later
    assert_plain_fwd_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && in_valid && in_flags == '0 && !ser_next)
        |=> out_valid && out_seq == $past(in_seq) && out_flags == '0);

    // R3: wait-after / store-conditional arms the one-shot request
    assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && in_valid && !ser_next && !in_flags[0] && !in_flags[5]
         && !in_flags[3] && (in_flags[4] || in_flags[2]))
        |=> ser_next && out_valid && out_flags[0]);

    // R4: the one-shot request is consumed by the next accepted instruction
    assert_consume_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && in_valid && ser_next) |=> !ser_next);

    // R5: unhandled barrier parks and raises stall
    assert_park_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && in_valid && !in_flags[0] && (in_flags[5] || in_flags[3] || ser_next))
        |=> stall_req && held_valid && !out_valid);

    // R7: input ignored while stalled
    assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> $stable(cnt_serial) && $stable(cnt_temp) && $stable(ser_next));

    // R8: stall cycles counted one by one
    assert_stall_cnt_R8: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> cnt_stall == CNT_W'($past(cnt_stall) + 1'b1));

endmodule

// File: tb/test_ser_barrier_tracker.sv
module test_ser_barrier_tracker;

    localparam int CLK_P = 10;
    localparam int SEQ_W = 16;
    localparam int TAG_W = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [SEQ_W-1:0] in_seq;
    logic [TAG_W-1:0] in_tag;
    logic [5:0]       in_flags;
    logic             rob_empty;
    logic             fq_empty;
    logic             squash_valid;
    logic [SEQ_W-1:0] squash_seq;
    logic             out_valid;
    logic [SEQ_W-1:0] out_seq;
    logic [TAG_W-1:0] out_tag;
    logic [5:0]       out_flags;
    logic             stall_req;
    logic             ser_next;
    logic             held_valid;
    logic [CNT_W-1:0] cnt_serial;
    logic [CNT_W-1:0] cnt_temp;
    logic [CNT_W-1:0] cnt_stall;

    int total = 0;
    int bad   = 0;
    int e_serial = 0;
    int e_temp   = 0;
    int e_stall  = 0;

    always #(CLK_P/2) clk = ~clk;

    ser_barrier_tracker #(.SEQ_W(SEQ_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_ser_barrier_tracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_seq(in_seq), .in_tag(in_tag),
        .in_flags(in_flags), .rob_empty(rob_empty), .fq_empty(fq_empty),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .out_valid(out_valid),
        .out_seq(out_seq), .out_tag(out_tag), .out_flags(out_flags), .stall_req(stall_req),
        .ser_next(ser_next), .held_valid(held_valid), .cnt_serial(cnt_serial),
        .cnt_temp(cnt_temp), .cnt_stall(cnt_stall)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_cnts(string req);
        check(req, "cnt_serial", cnt_serial, e_serial);
        check(req, "cnt_temp", cnt_temp, e_temp);
        check(req, "cnt_stall", cnt_stall, e_stall);
    endtask

    // drive one instruction for one edge; returns at the following negedge
    task automatic send(int seq, int tag, logic [5:0] fl);
        in_valid = 1'b1;
        in_seq   = SEQ_W'(seq);
        in_tag   = TAG_W'(tag);
        in_flags = fl;
        @(negedge clk);
        in_valid = 1'b0;
        in_flags = '0;
    endtask

    // two-edge release with both empty signals for one cycle
    task automatic release_and_check(string req, int seq, int tag, logic [5:0] fl);
        rob_empty = 1'b1;
        fq_empty  = 1'b1;
        @(negedge clk);
        e_stall++;
        rob_empty = 1'b0;
        fq_empty  = 1'b0;
        check(req, "stall during release", stall_req, 1'b1);
        check(req, "no early delivery", out_valid, 1'b0);
        @(negedge clk);
        e_stall++;
        check(req, "replay valid", out_valid, 1'b1);
        check(req, "replay seq", out_seq, seq);
        check(req, "replay tag", out_tag, tag);
        check(req, "replay flags", out_flags, fl);
        check(req, "stall dropped", stall_req, 1'b0);
        check(req, "slot empty", held_valid, 1'b0);
    endtask

    task automatic t_reset;
        check("R1", "out_valid", out_valid, 1'b0);
        check("R1", "stall_req", stall_req, 1'b0);
        check("R1", "ser_next", ser_next, 1'b0);
        check("R1", "held_valid", held_valid, 1'b0);
        check_cnts("R1");
    endtask

    task automatic t_plain;
        send(1, 32'h1000, 6'b000000);
        check("R2", "valid", out_valid, 1'b1);
        check("R2", "seq", out_seq, 1);
        check("R2", "tag", out_tag, 32'h1000);
        check("R2", "flags", out_flags, 6'b000000);
        send(2, 32'h1004, 6'b000010);
        check("R2", "temp-only flags", out_flags, 6'b000010);
        send(3, 32'h1008, 6'b110101);
        check("R2", "handled flags", out_flags, 6'b110101);
        check("R2", "seq3", out_seq, 3);
        check_cnts("R2");
        @(negedge clk);
        check("R2", "idle no output", out_valid, 1'b0);
    endtask

    task automatic t_after_chain;
        send(4, 32'h2000, 6'b000100);
        e_serial++;
        check("R3", "sc handled", out_flags, 6'b000101);
        check("R3", "ser_next set", ser_next, 1'b1);
        check_cnts("R3");
        send(5, 32'h2004, 6'b000001);
        check("R4", "forced before", out_flags, 6'b100001);
        check("R4", "ser_next clear", ser_next, 1'b0);
        check("R4", "forwarded", out_valid, 1'b1);
        send(6, 32'h2008, 6'b010000);
        e_serial++;
        check("R3", "after handled", out_flags, 6'b010001);
        check("R3", "ser_next set 2", ser_next, 1'b1);
        send(7, 32'h200c, 6'b000000);
        e_serial++;
        check("R5", "parked not forwarded", out_valid, 1'b0);
        check("R5", "stall", stall_req, 1'b1);
        check("R5", "held", held_valid, 1'b1);
        check("R4", "ser_next consumed", ser_next, 1'b0);
        check_cnts("R6");
        release_and_check("R9", 7, 32'h200c, 6'b000001);
        check_cnts("R8");
    endtask

    task automatic t_wait_long;
        send(10, 32'h3000, 6'b001000);
        e_serial++;
        check("R5", "spr parked", stall_req, 1'b1);
        rob_empty = 1'b1;
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1;
            in_seq   = SEQ_W'(50 + i);
            in_flags = 6'b000100;
            @(negedge clk);
            e_stall++;
            check("R7", "ignored no output", out_valid, 1'b0);
            check("R7", "no arm", ser_next, 1'b0);
            check("R9", "rob only keeps stall", stall_req, 1'b1);
        end
        in_valid  = 1'b0;
        in_flags  = '0;
        rob_empty = 1'b0;
        fq_empty  = 1'b1;
        @(negedge clk);
        e_stall++;
        fq_empty = 1'b0;
        check("R9", "fq only keeps stall", stall_req, 1'b1);
        check_cnts("R8");
        release_and_check("R6", 10, 32'h3000, 6'b001001);
        check_cnts("R8");
    endtask

    task automatic t_temp;
        send(12, 32'h4000, 6'b100010);
        e_temp++;
        check("R6", "temp parked", held_valid, 1'b1);
        check_cnts("R6");
        release_and_check("R6", 12, 32'h4000, 6'b000010);
        check_cnts("R6");
    endtask

    task automatic t_squash;
        send(20, 32'h5000, 6'b001000);
        e_serial++;
        squash_valid = 1'b1;
        squash_seq   = SEQ_W'(25);
        @(negedge clk);
        e_stall++;
        check("R10", "older point no effect", stall_req, 1'b1);
        check("R10", "slot kept", held_valid, 1'b1);
        squash_seq = SEQ_W'(20);
        @(negedge clk);
        e_stall++;
        check("R10", "equal point no effect", held_valid, 1'b1);
        squash_seq = SEQ_W'(10);
        @(negedge clk);
        e_stall++;
        squash_valid = 1'b0;
        check("R10", "stall cleared", stall_req, 1'b0);
        check("R10", "slot cleared", held_valid, 1'b0);
        check("R10", "no delivery", out_valid, 1'b0);
        rob_empty = 1'b1;
        fq_empty  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rob_empty = 1'b0;
        fq_empty  = 1'b0;
        check("R10", "no late replay", out_valid, 1'b0);
        check_cnts("R10");
        send(21, 32'h5004, 6'b000000);
        check("R10", "running again", out_seq, 21);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_seq = '0; in_tag = '0; in_flags = '0;
        rob_empty = 1'b0; fq_empty = 1'b0; squash_valid = 1'b0; squash_seq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_after_chain();
        t_wait_long();
        t_temp();
        t_squash();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule